// File: doc/BRIEF.md
# Ethernet Receive Address Filter

The filter sits on the receive path of an Ethernet MAC and decides, from the 48-bit destination address at the head of each frame, whether that frame is kept. The address arrives as a byte stream. A start strobe marks the first byte, and idle cycles may fall between bytes. As the bytes arrive the filter compares them against four exact-match entries and also computes a CRC-based hash into a 64-bit multicast table. One cycle after the last address byte it pulses a result strobe together with an accept decision and classification flags. These flags are meant for the receive descriptor status.

Entry 0 holds the station's own address and entries 1 to 3 hold exact multicast addresses. Firmware writes the entries, the hash table and two mode inputs (promiscuous, hash enable). The filter takes a copy of all of them when a frame starts, so configuration traffic never splits a frame's decision between an old setting and a new one.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset the result strobe and all result flags are 0, and every entry and hash word reads as zero. A frame addressed to 00:00:00:00:00:00 is therefore rejected with no exact hit.
- R2: The result strobe is high for exactly one cycle, namely the cycle after the clock edge that takes the sixth address byte. Idle cycles between bytes delay it by the same amount, and it is never high at any other time.
- R3: Entry e (0 to 3) is written as three 16-bit halves at byte offsets 0x10+8e (low), +2 (middle) and +4 (high). Each half holds two address bytes in wire order, the earlier byte in bits 7:0. A frame whose address equals a non-zero entry is accepted. An all-zero entry never matches.
- R4: The exact-hit flag is set when any non-zero entry matches. The 2-bit index reports the lowest-numbered matching entry, and it is 0 whenever the exact-hit flag is 0.
- R5: An all-ones address sets the broadcast flag, clears the multicast flag and is always accepted.
- R6: The multicast flag is set when bit 0 of the first address byte is 1 and the address is not all ones.
- R7: The hash value is bits 31:26 of a CRC-32 over the six address bytes. The CRC uses polynomial 0x04C11DB7, starts from all ones, takes each byte least significant bit first and is not inverted at the end. The hash table is four 16-bit words at offsets 0x00, 0x02, 0x04 and 0x06. Hash bits 5:4 select the word and bits 3:0 select the bit. When hashing is enabled and the frame is multicast, a set table bit raises the hash-hit flag and accepts the frame.
- R8: The hash-hit flag is 0 when hashing is disabled or the frame is not multicast, whatever the table holds.
- R9: In promiscuous mode every frame is accepted, and the classification flags are computed as usual.
- R10: The entries, the hash table and both mode inputs are sampled on the edge that takes a frame's first byte. Register writes or mode changes on that edge or later in the frame only affect the next frame.
- R11: A start strobe in the middle of an address restarts the lookup, and bytes that arrive while no frame is open are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 16 | Register write data |
| promisc_en | input | 1 | Accept every frame |
| hash_en | input | 1 | Enable multicast hash lookup |
| rx_valid | input | 1 | An address byte is present on rx_byte |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_byte | input | 8 | Destination address byte, wire order |
| res_valid | output | 1 | One-cycle result strobe |
| res_accept | output | 1 | Frame is accepted |
| res_bcast | output | 1 | Broadcast address |
| res_mcast | output | 1 | Multicast, non-broadcast address |
| res_hash_hit | output | 1 | Multicast hash table hit |
| res_exact_hit | output | 1 | Exact entry hit |
| res_exact_idx | output | 2 | Lowest matching entry number |

## Verification
Wrong internal state can come from the running CRC, the per-entry match flags or the byte counter, and all of it is cleared again at each frame start. A fault therefore shows up in the result of the same frame, one cycle after its sixth byte: a wrong hash-hit, a wrong index or accept, or a strobe that comes early, late or twice. A fault in the configuration copy shows up only on the frame after the write that exposes it. The bench therefore writes registers and toggles modes in the middle of a frame and checks both that frame and the following one.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

   localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

   // One byte through a left-shifting CRC-32, data bits taken LSB first.
   function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                 input logic [7:0]  d,
                                                 input logic [31:0] poly);
      logic [31:0] c;
      c = c_in;
      for (int i = 0; i < 8; i++) begin
         if (c[31] ^ d[i]) c = {c[30:0], 1'b0} ^ poly;
         else              c = {c[30:0], 1'b0};
      end
      return c;
   endfunction

endpackage

// File: rtl/rxaf_cfg_bank.sv
module rxaf_cfg_bank #(
   parameter int N_ENT      = 4,
   parameter int ADDR_BYTES = 6,
   parameter int HASH_WORDS = 4,
   parameter int CFG_AW     = 8,
   parameter int ENT_BASE   = 16,
   parameter int ENT_STRIDE = 8,
   parameter int HASH_BASE  = 0
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    we,
   input  logic [CFG_AW-1:0]                       addr,
   input  logic [15:0]                             wdata,
   input  logic                                    promisc_in,
   input  logic                                    hashen_in,
   input  logic                                    load,
   output logic [N_ENT-1:0][8*ADDR_BYTES-1:0]      ent_eff,
   output logic [16*HASH_WORDS-1:0]                hash_eff,
   output logic                                    promisc_eff,
   output logic                                    hashen_eff
);
   localparam int HALVES = ADDR_BYTES / 2;
   localparam int AW     = 8 * ADDR_BYTES;

   logic [N_ENT-1:0][AW-1:0] ent_stg, ent_act;
   logic [16*HASH_WORDS-1:0] hash_stg, hash_act;
   logic                     promisc_act, hashen_act;

   // Staging copy: written at any time by the register port.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_stg  <= '0;
         hash_stg <= '0;
      end else if (we) begin
         for (int e = 0; e < N_ENT; e++)
            for (int h = 0; h < HALVES; h++)
               if (addr == CFG_AW'(ENT_BASE + e * ENT_STRIDE + 2 * h))
                  ent_stg[e][16*h +: 16] <= wdata;
         for (int w = 0; w < HASH_WORDS; w++)
            if (addr == CFG_AW'(HASH_BASE + 2 * w))
               hash_stg[16*w +: 16] <= wdata;
      end
   end

   // Active copy: frozen for the duration of one frame.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_act     <= '0;
         hash_act    <= '0;
         promisc_act <= 1'b0;
         hashen_act  <= 1'b0;
      end else if (load) begin
         ent_act     <= ent_stg;
         hash_act    <= hash_stg;
         promisc_act <= promisc_in;
         hashen_act  <= hashen_in;
      end
   end

   // The first byte of a frame already sees what is being captured.
   assign ent_eff     = load ? ent_stg    : ent_act;
   assign hash_eff    = load ? hash_stg   : hash_act;
   assign promisc_eff = load ? promisc_in : promisc_act;
   assign hashen_eff  = load ? hashen_in  : hashen_act;

endmodule

// File: rtl/rxaf_hash_crc.sv
module rxaf_hash_crc
   import rxaf_pkg::*;
#(
   parameter int          HASH_BITS = 6,
   parameter logic [31:0] POLY      = 32'h04C1_1DB7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 byte_en,
   input  logic                 first,
   input  logic [7:0]           byte_in,
   output logic [HASH_BITS-1:0] hash_next
);
   logic [31:0] crc_q, seed, crc_d;

   assign seed      = first ? CRC_SEED : crc_q;
   assign crc_d     = crc_step_byte(seed, byte_in, POLY);
   assign hash_next = crc_d[31 -: HASH_BITS];

   always_ff @(posedge clk) begin
      if (!rst_n)       crc_q <= CRC_SEED;
      else if (byte_en) crc_q <= crc_d;
   end

endmodule

// File: rtl/rxaf_exact_match.sv
module rxaf_exact_match #(
   parameter int N_ENT      = 4,
   parameter int ADDR_BYTES = 6,
   parameter int CW         = 3
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                byte_en,
   input  logic                                first,
   input  logic [CW-1:0]                       byte_idx,
   input  logic [7:0]                          byte_in,
   input  logic [N_ENT-1:0][8*ADDR_BYTES-1:0]  ent,
   output logic [N_ENT-1:0]                    hit_next
);
   for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      logic                       run_q, run_d;
      logic [ADDR_BYTES-1:0][7:0] view;

      assign view        = ent[e];
      assign run_d       = (first | run_q) & (byte_in == view[byte_idx]);
      assign hit_next[e] = run_d & (|ent[e]);

      always_ff @(posedge clk) begin
         if (!rst_n)       run_q <= 1'b0;
         else if (byte_en) run_q <= run_d;
      end
   end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
   parameter int          N_ENT      = 4,
   parameter int          ADDR_BYTES = 6,
   parameter int          HASH_BITS  = 6,
   parameter int          CFG_AW     = 8,
   parameter int          ENT_BASE   = 16,
   parameter int          ENT_STRIDE = 8,
   parameter int          HASH_BASE  = 0,
   parameter logic [31:0] CRC_POLY   = 32'h04C1_1DB7,
   localparam int         IDX_W      = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [15:0]       cfg_wdata,
   input  logic              promisc_en,
   input  logic              hash_en,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic [7:0]        rx_byte,
   output logic              res_valid,
   output logic              res_accept,
   output logic              res_bcast,
   output logic              res_mcast,
   output logic              res_hash_hit,
   output logic              res_exact_hit,
   output logic [IDX_W-1:0]  res_exact_idx
);
   localparam int AW         = 8 * ADDR_BYTES;
   localparam int HASH_WORDS = 1 << (HASH_BITS - 4);
   localparam int CW         = $clog2(ADDR_BYTES + 1);
   localparam int LAST_IDX   = ADDR_BYTES - 1;

   // Elaboration-time parameter checks.
   if (ADDR_BYTES < 2 || (ADDR_BYTES % 2) != 0) begin : g_bad_bytes
      $error("ADDR_BYTES must be even and at least 2");
   end
   if (HASH_BITS < 4 || HASH_BITS > 10) begin : g_bad_hash
      $error("HASH_BITS must lie in 4..10");
   end
   if (N_ENT < 1) begin : g_bad_ent
      $error("N_ENT must be at least 1");
   end
   if (ENT_STRIDE < ADDR_BYTES) begin : g_bad_stride
      $error("ENT_STRIDE too small for one entry");
   end
   if (ENT_BASE < HASH_BASE + 2 * HASH_WORDS && HASH_BASE < ENT_BASE + N_ENT * ENT_STRIDE) begin : g_overlap
      $error("hash table and entries overlap");
   end
   if (ENT_BASE + N_ENT * ENT_STRIDE > (1 << CFG_AW)) begin : g_bad_aw
      $error("register map exceeds CFG_AW");
   end

   // ---------------- byte sequencing ----------------
   logic          busy;
   logic [CW-1:0] cnt;
   logic          first, take, last;
   logic [CW-1:0] byte_idx;

   assign first    = rx_valid & rx_sof;
   assign take     = rx_valid & (rx_sof | busy);
   assign last     = take & ~first & (cnt == CW'(LAST_IDX));
   assign byte_idx = first ? '0 : cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (first) begin
         busy <= 1'b1;
         cnt  <= CW'(1);
      end else if (take) begin
         cnt <= cnt + CW'(1);
         if (cnt == CW'(LAST_IDX)) busy <= 1'b0;
      end
   end

   // ---------------- configuration ----------------
   logic [N_ENT-1:0][AW-1:0] ent_eff;
   logic [16*HASH_WORDS-1:0] hash_eff;
   logic                     promisc_eff, hashen_eff;

   rxaf_cfg_bank #(
      .N_ENT(N_ENT), .ADDR_BYTES(ADDR_BYTES), .HASH_WORDS(HASH_WORDS),
      .CFG_AW(CFG_AW), .ENT_BASE(ENT_BASE), .ENT_STRIDE(ENT_STRIDE),
      .HASH_BASE(HASH_BASE)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .promisc_in(promisc_en), .hashen_in(hash_en), .load(first),
      .ent_eff(ent_eff), .hash_eff(hash_eff),
      .promisc_eff(promisc_eff), .hashen_eff(hashen_eff)
   );

   // ---------------- hash ----------------
   logic [HASH_BITS-1:0] hash_next;

   rxaf_hash_crc #(.HASH_BITS(HASH_BITS), .POLY(CRC_POLY)) u_crc (
      .clk(clk), .rst_n(rst_n), .byte_en(take), .first(first),
      .byte_in(rx_byte), .hash_next(hash_next)
   );

   // ---------------- exact entries ----------------
   logic [N_ENT-1:0] hit_next;

   rxaf_exact_match #(.N_ENT(N_ENT), .ADDR_BYTES(ADDR_BYTES), .CW(CW)) u_match (
      .clk(clk), .rst_n(rst_n), .byte_en(take), .first(first),
      .byte_idx(byte_idx), .byte_in(rx_byte), .ent(ent_eff), .hit_next(hit_next)
   );

   // ---------------- address class ----------------
   logic ones_q, ones_d, grp_q, grp_d;

   assign ones_d = (first | ones_q) & (&rx_byte);
   assign grp_d  = first ? rx_byte[0] : grp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ones_q <= 1'b0;
         grp_q  <= 1'b0;
      end else if (take) begin
         ones_q <= ones_d;
         grp_q  <= grp_d;
      end
   end

   // ---------------- decision ----------------
   logic             d_bc, d_mc, d_hh, d_ex, d_acc;
   logic [IDX_W-1:0] d_idx;

   always_comb begin
      d_idx = '0;
      for (int e = N_ENT - 1; e >= 0; e--)
         if (hit_next[e]) d_idx = IDX_W'(e);
   end

   assign d_bc  = ones_d;
   assign d_mc  = grp_d & ~ones_d;
   assign d_hh  = hashen_eff & d_mc & hash_eff[hash_next];
   assign d_ex  = |hit_next;
   assign d_acc = promisc_eff | d_bc | d_ex | d_hh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid     <= 1'b0;
         res_accept    <= 1'b0;
         res_bcast     <= 1'b0;
         res_mcast     <= 1'b0;
         res_hash_hit  <= 1'b0;
         res_exact_hit <= 1'b0;
         res_exact_idx <= '0;
      end else begin
         res_valid <= last;
         if (last) begin
            res_accept    <= d_acc;
            res_bcast     <= d_bc;
            res_mcast     <= d_mc;
            res_hash_hit  <= d_hh;
            res_exact_hit <= d_ex;
            res_exact_idx <= d_idx;
         end
      end
   end

   // ---------------- assertions ----------------
   // R2
   res_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(rx_valid));
   // R2
   res_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   // R11
   byte_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(ADDR_BYTES));
   // R5
   bcast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_bcast) |-> (res_accept && !res_mcast));
   // R4
   idx_zero_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_exact_hit) |-> (res_exact_idx == '0));
   // R8
   hash_needs_mcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_hash_hit) |-> (res_mcast && res_accept));

endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        promisc_en = 1'b0;
   logic        hash_en = 1'b0;
   logic        rx_valid = 1'b0;
   logic        rx_sof = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        res_valid, res_accept, res_bcast, res_mcast;
   logic        res_hash_hit, res_exact_hit;
   logic [1:0]  res_exact_idx;

   always #4 clk = ~clk;

   rx_addr_filter u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .promisc_en(promisc_en), .hash_en(hash_en),
      .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_byte(rx_byte),
      .res_valid(res_valid), .res_accept(res_accept), .res_bcast(res_bcast),
      .res_mcast(res_mcast), .res_hash_hit(res_hash_hit),
      .res_exact_hit(res_exact_hit), .res_exact_idx(res_exact_idx)
   );

   int n_chk = 0;
   int n_bad = 0;

   logic [47:0] ent [4];
   logic [63:0] htab;

   // Address constants, first wire byte in bits 47:40.
   localparam logic [47:0] STA   = 48'h02_11_22_33_44_55;
   localparam logic [47:0] MC_A  = 48'h01_00_5E_00_00_01;
   localparam logic [47:0] MC_B  = 48'h01_80_C2_00_00_0E;
   localparam logic [47:0] MC_H  = 48'h33_33_00_00_00_01;
   localparam logic [47:0] MC_X  = 48'h01_00_5E_7F_00_09;
   localparam logic [47:0] UNI_Y = 48'h00_1B_21_AA_BB_CC;

   // {address, promiscuous, hash enable}
   localparam logic [49:0] VECS [12] = '{
      {STA,                1'b0, 1'b0},
      {UNI_Y,              1'b0, 1'b0},
      {48'hFFFF_FFFF_FFFF, 1'b0, 1'b0},
      {MC_A,               1'b0, 1'b0},
      {MC_B,               1'b0, 1'b1},
      {MC_H,               1'b0, 1'b1},
      {MC_H,               1'b0, 1'b0},
      {48'h33_33_FF_00_00_07, 1'b0, 1'b1},
      {UNI_Y,              1'b1, 1'b0},
      {48'h0,              1'b0, 1'b1},
      {48'h32_33_00_00_00_01, 1'b0, 1'b1},
      {48'h01_00_5E_11_22_33, 1'b1, 1'b0}
   };

   function automatic logic [7:0] da_byte(input logic [47:0] da, input int k);
      return da[47 - 8*k -: 8];
   endfunction

   function automatic logic [5:0] hash_of(input logic [47:0] da);
      logic [31:0] c;
      c = 32'hFFFF_FFFF;
      for (int k = 0; k < 6; k++) begin
         logic [7:0] b;
         b = da_byte(da, k);
         for (int i = 0; i < 8; i++) begin
            logic fb;
            fb = c[31] ^ b[i];
            c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
         end
      end
      return c[31:26];
   endfunction

   // {valid, accept, bcast, mcast, hash_hit, exact_hit, idx[1:0]}
   function automatic logic [7:0] model(input logic [47:0] da, input logic pr, input logic he);
      logic bc, mc, hh, ex, acc;
      logic [1:0] idx;
      bc  = (da == 48'hFFFF_FFFF_FFFF);
      mc  = da[40] & ~bc;
      hh  = he & mc & htab[hash_of(da)];
      ex  = 1'b0;
      idx = 2'd0;
      for (int e = 3; e >= 0; e--)
         if (ent[e] != 48'h0 && ent[e] == da) begin
            ex  = 1'b1;
            idx = 2'(e);
         end
      acc = pr | bc | ex | hh;
      return {1'b1, acc, bc, mc, hh, ex, idx};
   endfunction

   function automatic logic [7:0] outs();
      return {res_valid, res_accept, res_bcast, res_mcast,
              res_hash_hit, res_exact_hit, res_exact_idx};
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wr_entry(input int e, input logic [47:0] da);
      for (int h = 0; h < 3; h++)
         wr_reg(8'(16 + 8*e + 2*h), {da_byte(da, 2*h+1), da_byte(da, 2*h)});
      ent[e] = da;
   endtask

   // Drives one address; returns outputs at the negedge after the last byte
   // and whether the strobe was seen earlier.
   task automatic send(input logic [47:0] da, input logic pr, input logic he,
                       input int gap, output logic [7:0] got, output logic early);
      early = 1'b0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         early |= res_valid;
         rx_valid = 1'b1; rx_sof = (k == 0); rx_byte = da_byte(da, k);
         promisc_en = pr; hash_en = he;
         if (k < 5)
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               early |= res_valid;
               rx_valid = 1'b0; rx_sof = 1'b0;
            end
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0;
      got = outs();
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
   end

   initial begin : main
      logic [7:0] got;
      logic       early;
      logic [5:0] hv;
      for (int e = 0; e < 4; e++) ent[e] = 48'h0;
      htab = '0;

      repeat (3) @(negedge clk);
      // R1: outputs during and after reset
      check("R1 reset outputs", outs(), 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", outs(), 8'h00);

      // R1 R3: all-zero entries never match a zero address
      send(48'h0, 1'b0, 1'b0, 0, got, early);
      check("R1 R3 zero entry no match", got, model(48'h0, 1'b0, 1'b0));

      // Configuration: station, multicast slots, one hash bit
      wr_entry(0, STA);
      wr_entry(1, MC_A);
      wr_entry(2, MC_B);
      wr_entry(3, MC_A);
      hv = hash_of(MC_H);
      htab[hv] = 1'b1;
      for (int w = 0; w < 4; w++) wr_reg(8'(2*w), htab[16*w +: 16]);

      // Table walk: R3 R4 R5 R6 R7 R8 R9
      for (int i = 0; i < 12; i++) begin
         send(VECS[i][49:2], VECS[i][1], VECS[i][0], 0, got, early);
         check($sformatf("R3-vector %0d (R4 R5 R6 R7 R8 R9)", i), got,
               model(VECS[i][49:2], VECS[i][1], VECS[i][0]));
      end

      // R7: the configured hash bit must produce a hash hit
      send(MC_H, 1'b0, 1'b1, 0, got, early);
      check("R7 hash hit", {got[3], got[6]}, 2'b11);
      // R4: duplicate slots report the lower index
      send(MC_A, 1'b0, 1'b0, 0, got, early);
      check("R4 lowest index", got[1:0], 2'd1);

      // R2: gaps between bytes; strobe exactly one cycle after sixth byte
      send(STA, 1'b0, 1'b0, 2, got, early);
      check("R2 no early strobe", {7'b0, early}, 8'h00);
      check("R2 strobe after last byte", got, model(STA, 1'b0, 1'b0));
      @(negedge clk);
      check("R2 strobe one cycle", {7'b0, res_valid}, 8'h00);

      // R11: bytes with no open frame are ignored
      early = 1'b0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         early |= res_valid;
         rx_valid = 1'b1; rx_sof = 1'b0; rx_byte = 8'hFF;
      end
      @(negedge clk);
      early |= res_valid;
      rx_valid = 1'b0;
      @(negedge clk);
      early |= res_valid;
      check("R11 stray bytes ignored", {7'b0, early}, 8'h00);

      // R11: restart in mid-address
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_sof = (k == 0); rx_byte = 8'hFF;
      end
      send(STA, 1'b0, 1'b0, 0, got, early);
      check("R11 restart no strobe", {7'b0, early}, 8'h00);
      check("R11 restart result", got, model(STA, 1'b0, 1'b0));

      // R10: entry 1 rewritten during a frame addressed to the new value
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_sof = (k == 0); rx_byte = da_byte(MC_X, k);
         promisc_en = 1'b0; hash_en = 1'b0;
         cfg_we = (k >= 1 && k <= 3);
         cfg_addr = 8'(24 + 2*(k-1));
         cfg_wdata = {da_byte(MC_X, 2*(k-1)+1), da_byte(MC_X, 2*(k-1))};
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; cfg_we = 1'b0;
      check("R10 write mid-frame deferred", outs(), model(MC_X, 1'b0, 1'b0));
      ent[1] = MC_X;
      send(MC_X, 1'b0, 1'b0, 0, got, early);
      check("R10 write applies next frame", got, model(MC_X, 1'b0, 1'b0));

      // R10: promiscuous raised after the first byte has no effect
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_sof = (k == 0); rx_byte = da_byte(UNI_Y, k);
         promisc_en = (k >= 1); hash_en = 1'b0;
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0;
      check("R10 mode sampled at start", outs(), model(UNI_Y, 1'b0, 1'b0));
      send(UNI_Y, 1'b1, 1'b0, 0, got, early);
      check("R9 R10 promiscuous next frame", got, model(UNI_Y, 1'b1, 1'b0));

      summary();
   end

endmodule